// File: doc/BRIEF.md
# Reversible Toffoli Cascade Evaluator with Missing-Gate Injection

This block holds a programmable cascade of multiple-controlled Toffoli gates acting on a bus of wires. It evaluates an input vector through the cascade in one clock cycle. A gate fires when every wire in its control set is 1, and it then inverts its single target wire. All other wires pass through unchanged. Because each gate is its own inverse, running the cascade in the opposite order undoes a forward pass.

Each gate slot is loaded through a write port with a control mask and a target wire index. The number of slots in use is a separate register. A fault register can name a contiguous span of slots as absent. Every evaluation computes two results side by side: a fault-free one and one with the span removed. The block returns both results and flags whether they differ, which shows whether a given vector exposes a missing-gate fault.

Top module: `rev_cascade_eval`

## Requirements
- R1: After reset `done`, `vec_out`, `ref_out` and `mismatch` are 0, every slot holds an empty mask with target 0, the slot count is 0 and injection is off. With count 0 an evaluation returns the input vector unchanged.
- R2: A live gate inverts wire `t` (bit `t` of the vector, wire 0 is bit 0) exactly when every bit set in its mask is 1 in the incoming vector. No other wire changes. A gate with an empty mask always inverts its target. A mask bit on the target wire itself is not treated as a control.
- R3: With `reverse`=0, slots 0 up to count-1 are applied in ascending order, each to the result of the one before. Slots at or above the count have no effect.
- R4: With `reverse`=1, the live slots are applied in descending order. Reverse-evaluating the fault-free output of a forward pass returns the original input.
- R5: While injection is on, slots `first` through `last` inclusive are skipped in `vec_out` only. `ref_out` always has every live slot applied. With injection off, `vec_out` equals `ref_out`.
- R6: `mismatch` is 1 exactly when `vec_out` differs from `ref_out`.
- R7: When two consecutive identical gates are skipped together, they cancel, and `vec_out` equals `ref_out`.
- R8: A fault-register write with `flt_first` greater than `flt_last` is rejected, and the previous injection setting stays in force.
- R9: `done` pulses for exactly one cycle, one cycle after `start`. The result outputs change only in that cycle and hold their values otherwise.
- R10: An evaluation started in the same cycle as a gate, count or fault write uses the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_we | input | 1 | Write one gate slot |
| gate_slot | input | GIDX_W | Slot index to write |
| gate_mask | input | WIRES | Control mask for the slot |
| gate_target | input | TIDX_W | Target wire index for the slot |
| count_we | input | 1 | Write the number of slots in use |
| count_value | input | CNT_W | Number of slots in use |
| flt_we | input | 1 | Write the injection setting |
| flt_enable | input | 1 | Injection on |
| flt_first | input | GIDX_W | First skipped slot |
| flt_last | input | GIDX_W | Last skipped slot |
| start | input | 1 | Evaluate `vec_in` |
| reverse | input | 1 | 1 selects descending slot order |
| vec_in | input | WIRES | Vector to evaluate |
| done | output | 1 | Result valid strobe |
| vec_out | output | WIRES | Result with the skipped span removed |
| ref_out | output | WIRES | Fault-free result |
| mismatch | output | 1 | Results differ |

## Verification
A configuration write and an evaluation can land in the same cycle. The bench raises `start` together with a fault-register write that turns injection off. It expects the result of that cycle to still show the injected mismatch, and the next evaluation to show none. It uses the same overlap with a gate write and checks that the new gate affects only the following evaluation. A rejected fault write is judged by the next evaluation, which must still show the skipped span that was set before the write.

// File: rtl/rev_cascade_pkg.sv
package rev_cascade_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

endpackage

// File: rtl/rev_gate_stage.sv
module rev_gate_stage #(
    parameter int WIRES  = 8,
    parameter int TIDX_W = 3
) (
    input  logic [WIRES-1:0]  vec_i,
    input  logic [WIRES-1:0]  mask_i,
    input  logic [TIDX_W-1:0] target_i,
    input  logic              live_i,
    output logic [WIRES-1:0]  vec_o
);
    logic [WIRES-1:0] tbit;
    logic [WIRES-1:0] ctl;
    logic             fire;

    always_comb begin
        tbit = '0;
        if (int'(target_i) < WIRES) begin
            tbit[target_i] = 1'b1;
        end
        // the target wire never acts as its own control
        ctl   = mask_i & ~tbit;
        fire  = live_i && ((vec_i & ctl) == ctl);
        vec_o = fire ? (vec_i ^ tbit) : vec_i;
    end

endmodule

// File: rtl/rev_cascade_chain.sv
module rev_cascade_chain
    import rev_cascade_pkg::*;
#(
    parameter int WIRES     = 8,
    parameter int MAX_GATES = 32,
    parameter int TIDX_W    = 3,
    parameter int GIDX_W    = 5,
    parameter int CNT_W     = 6
) (
    input  logic [WIRES-1:0]                    vec_i,
    input  logic [MAX_GATES-1:0][WIRES-1:0]     masks_i,
    input  logic [MAX_GATES-1:0][TIDX_W-1:0]    targets_i,
    input  logic [CNT_W-1:0]                    count_i,
    input  dir_e                                dir_i,
    input  logic                                skip_en_i,
    input  logic [GIDX_W-1:0]                   skip_first_i,
    input  logic [GIDX_W-1:0]                   skip_last_i,
    output logic [WIRES-1:0]                    vec_o
);
    logic [WIRES-1:0] stage_v [MAX_GATES+1];

    assign stage_v[0] = vec_i;

    for (genvar j = 0; j < MAX_GATES; j++) begin : g_stage
        localparam logic [GIDX_W-1:0] FWD_IDX = GIDX_W'(j);
        localparam logic [GIDX_W-1:0] BWD_IDX = GIDX_W'(MAX_GATES - 1 - j);

        logic [GIDX_W-1:0] slot;
        logic              live;

        assign slot = (dir_i == DIR_REV) ? BWD_IDX : FWD_IDX;
        assign live = (CNT_W'(slot) < count_i) &&
                      !(skip_en_i && (slot >= skip_first_i) && (slot <= skip_last_i));

        rev_gate_stage #(
            .WIRES  (WIRES),
            .TIDX_W (TIDX_W)
        ) u_stage (
            .vec_i    (stage_v[j]),
            .mask_i   (masks_i[slot]),
            .target_i (targets_i[slot]),
            .live_i   (live),
            .vec_o    (stage_v[j+1])
        );
    end

    assign vec_o = stage_v[MAX_GATES];

endmodule

// File: rtl/rev_cascade_eval.sv
module rev_cascade_eval
    import rev_cascade_pkg::*;
#(
    parameter  int WIRES     = 8,
    parameter  int MAX_GATES = 32,
    localparam int TIDX_W    = (WIRES > 1) ? $clog2(WIRES) : 1,
    localparam int GIDX_W    = (MAX_GATES > 1) ? $clog2(MAX_GATES) : 1,
    localparam int CNT_W     = $clog2(MAX_GATES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_we,
    input  logic [GIDX_W-1:0] gate_slot,
    input  logic [WIRES-1:0]  gate_mask,
    input  logic [TIDX_W-1:0] gate_target,
    input  logic              count_we,
    input  logic [CNT_W-1:0]  count_value,
    input  logic              flt_we,
    input  logic              flt_enable,
    input  logic [GIDX_W-1:0] flt_first,
    input  logic [GIDX_W-1:0] flt_last,
    input  logic              start,
    input  logic              reverse,
    input  logic [WIRES-1:0]  vec_in,
    output logic              done,
    output logic [WIRES-1:0]  vec_out,
    output logic [WIRES-1:0]  ref_out,
    output logic              mismatch
);
    typedef struct packed {
        logic [MAX_GATES-1:0][WIRES-1:0]  masks;
        logic [MAX_GATES-1:0][TIDX_W-1:0] targets;
        logic [CNT_W-1:0]                 count;
        logic                             flt_on;
        logic [GIDX_W-1:0]                flt_first;
        logic [GIDX_W-1:0]                flt_last;
        logic                             done;
        logic [WIRES-1:0]                 vout;
        logic [WIRES-1:0]                 rout;
        logic                             mis;
    } state_t;

    state_t           st_d, st_q;
    logic [WIRES-1:0] faulty_w, clean_w;
    logic             fault_on_w;
    logic [GIDX_W-1:0] fault_first_w, fault_last_w;
    dir_e             dir_w;

    assign dir_w = dir_e'(reverse);

    rev_cascade_chain #(
        .WIRES(WIRES), .MAX_GATES(MAX_GATES), .TIDX_W(TIDX_W),
        .GIDX_W(GIDX_W), .CNT_W(CNT_W)
    ) u_faulty (
        .vec_i        (vec_in),
        .masks_i      (st_q.masks),
        .targets_i    (st_q.targets),
        .count_i      (st_q.count),
        .dir_i        (dir_w),
        .skip_en_i    (st_q.flt_on),
        .skip_first_i (st_q.flt_first),
        .skip_last_i  (st_q.flt_last),
        .vec_o        (faulty_w)
    );

    rev_cascade_chain #(
        .WIRES(WIRES), .MAX_GATES(MAX_GATES), .TIDX_W(TIDX_W),
        .GIDX_W(GIDX_W), .CNT_W(CNT_W)
    ) u_clean (
        .vec_i        (vec_in),
        .masks_i      (st_q.masks),
        .targets_i    (st_q.targets),
        .count_i      (st_q.count),
        .dir_i        (dir_w),
        .skip_en_i    (1'b0),
        .skip_first_i (st_q.flt_first),
        .skip_last_i  (st_q.flt_last),
        .vec_o        (clean_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (gate_we && (int'(gate_slot) < MAX_GATES)) begin
            st_d.masks[gate_slot]   = gate_mask;
            st_d.targets[gate_slot] = gate_target;
        end
        if (count_we) begin
            st_d.count = count_value;
        end
        if (flt_we && (flt_first <= flt_last)) begin
            st_d.flt_on    = flt_enable;
            st_d.flt_first = flt_first;
            st_d.flt_last  = flt_last;
        end
        if (start) begin
            st_d.vout = faulty_w;
            st_d.rout = clean_w;
            st_d.mis  = (faulty_w != clean_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done          = st_q.done;
    assign vec_out       = st_q.vout;
    assign ref_out       = st_q.rout;
    assign mismatch      = st_q.mis;
    assign fault_on_w    = st_q.flt_on;
    assign fault_first_w = st_q.flt_first;
    assign fault_last_w  = st_q.flt_last;

endmodule

// File: rtl/rev_cascade_chk.sv
module rev_cascade_chk #(
    parameter int WIRES  = 8,
    parameter int GIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [WIRES-1:0]  vec_out,
    input logic [WIRES-1:0]  ref_out,
    input logic              mismatch,
    input logic              flt_we,
    input logic [GIDX_W-1:0] flt_first,
    input logic [GIDX_W-1:0] flt_last,
    input logic              fault_on,
    input logic [GIDX_W-1:0] fault_first_q,
    input logic [GIDX_W-1:0] fault_last_q
);
    p_done_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(vec_out) && $stable(ref_out) && $stable(mismatch)));

    p_clean_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(fault_on)) |-> !mismatch);

    p_flag_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mismatch == (vec_out != ref_out)));

    p_reject_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_we && (flt_first > flt_last)) |=>
            ($stable(fault_on) && $stable(fault_first_q) && $stable(fault_last_q)));

endmodule

bind rev_cascade_eval rev_cascade_chk #(
    .WIRES  (WIRES),
    .GIDX_W (GIDX_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .done          (done),
    .vec_out       (vec_out),
    .ref_out       (ref_out),
    .mismatch      (mismatch),
    .flt_we        (flt_we),
    .flt_first     (flt_first),
    .flt_last      (flt_last),
    .fault_on      (fault_on_w),
    .fault_first_q (fault_first_w),
    .fault_last_q  (fault_last_w)
);

// File: tb/test_rev_cascade_eval.sv
module test_rev_cascade_eval;

    localparam int WIRES  = 8;
    localparam int GATES  = 32;
    localparam int TIDX_W = 3;
    localparam int GIDX_W = 5;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              gate_we = 1'b0;
    logic [GIDX_W-1:0] gate_slot = '0;
    logic [WIRES-1:0]  gate_mask = '0;
    logic [TIDX_W-1:0] gate_target = '0;
    logic              count_we = 1'b0;
    logic [CNT_W-1:0]  count_value = '0;
    logic              flt_we = 1'b0;
    logic              flt_enable = 1'b0;
    logic [GIDX_W-1:0] flt_first = '0;
    logic [GIDX_W-1:0] flt_last = '0;
    logic              start = 1'b0;
    logic              reverse = 1'b0;
    logic [WIRES-1:0]  vec_in = '0;
    logic              done;
    logic [WIRES-1:0]  vec_out;
    logic [WIRES-1:0]  ref_out;
    logic              mismatch;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rev_cascade_eval #(.WIRES(WIRES), .MAX_GATES(GATES)) i_rev_cascade_eval (
        .clk(clk), .rst_n(rst_n),
        .gate_we(gate_we), .gate_slot(gate_slot), .gate_mask(gate_mask),
        .gate_target(gate_target),
        .count_we(count_we), .count_value(count_value),
        .flt_we(flt_we), .flt_enable(flt_enable), .flt_first(flt_first),
        .flt_last(flt_last),
        .start(start), .reverse(reverse), .vec_in(vec_in),
        .done(done), .vec_out(vec_out), .ref_out(ref_out), .mismatch(mismatch)
    );

    typedef struct packed {
        logic              rev;
        logic              fen;
        logic [GIDX_W-1:0] first;
        logic [GIDX_W-1:0] last;
        logic [WIRES-1:0]  vin;
        logic [WIRES-1:0]  eout;
        logic [WIRES-1:0]  eref;
        logic              emis;
    } row_t;

    // cascade: s0 w0->w1, s1 w0&w1->w2, s2 w1&w2&w3->w4, s3 NOT w7
    localparam int NROWS = 13;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 1'b0, 5'd0, 5'd0, 8'h0F, 8'h8D, 8'h8D, 1'b0},
        '{1'b0, 1'b0, 5'd0, 5'd0, 8'h01, 8'h87, 8'h87, 1'b0},
        '{1'b0, 1'b0, 5'd0, 5'd0, 8'h0D, 8'h8B, 8'h8B, 1'b0},
        '{1'b0, 1'b0, 5'd0, 5'd0, 8'h0B, 8'h89, 8'h89, 1'b0},
        '{1'b0, 1'b0, 5'd0, 5'd0, 8'h0E, 8'h9E, 8'h9E, 1'b0},
        '{1'b1, 1'b0, 5'd0, 5'd0, 8'h87, 8'h01, 8'h01, 1'b0},
        '{1'b1, 1'b0, 5'd0, 5'd0, 8'h9E, 8'h0E, 8'h0E, 1'b0},
        '{1'b0, 1'b1, 5'd1, 5'd1, 8'h01, 8'h83, 8'h87, 1'b1},
        '{1'b0, 1'b1, 5'd0, 5'd1, 8'h0F, 8'h9F, 8'h8D, 1'b1},
        '{1'b0, 1'b1, 5'd0, 5'd0, 8'h0E, 8'h9E, 8'h9E, 1'b0},
        '{1'b0, 1'b1, 5'd3, 5'd3, 8'h00, 8'h00, 8'h80, 1'b1},
        '{1'b1, 1'b1, 5'd1, 5'd1, 8'h87, 8'h05, 8'h01, 1'b1},
        '{1'b0, 1'b0, 5'd0, 5'd3, 8'h01, 8'h87, 8'h87, 1'b0}
    };

    task automatic check(input string req, input logic [WIRES-1:0] act,
                         input logic [WIRES-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_gate(input int slot, input logic [WIRES-1:0] m, input int t);
        @(negedge clk);
        gate_we = 1'b1; gate_slot = GIDX_W'(slot); gate_mask = m;
        gate_target = TIDX_W'(t);
        @(negedge clk);
        gate_we = 1'b0;
    endtask

    task automatic put_count(input int c);
        @(negedge clk);
        count_we = 1'b1; count_value = CNT_W'(c);
        @(negedge clk);
        count_we = 1'b0;
    endtask

    task automatic put_fault(input logic en, input int f, input int l);
        @(negedge clk);
        flt_we = 1'b1; flt_enable = en;
        flt_first = GIDX_W'(f); flt_last = GIDX_W'(l);
        @(negedge clk);
        flt_we = 1'b0;
    endtask

    // drives start at a negedge; results are read at the following negedge
    task automatic eval(input logic rev, input logic [WIRES-1:0] v);
        @(negedge clk);
        start = 1'b1; reverse = rev; vec_in = v;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {7'd0, done}, 8'h00);
        check("R1 vec_out", vec_out, 8'h00);
        check("R1 ref_out", ref_out, 8'h00);
        check("R1 mismatch", {7'd0, mismatch}, 8'h00);
        rst_n = 1'b1;
        eval(1'b0, 8'h5A);
        check("R1 empty cascade", vec_out, 8'h5A);

        // R9 done pulse and holding
        check("R9 done high", {7'd0, done}, 8'h01);
        @(negedge clk);
        check("R9 done low", {7'd0, done}, 8'h00);
        check("R9 hold", vec_out, 8'h5A);

        put_gate(0, 8'b0000_0001, 1);
        put_gate(1, 8'b0000_0011, 2);
        put_gate(2, 8'b0000_1110, 4);
        put_gate(3, 8'b0000_0000, 7);
        put_count(4);

        for (int i = 0; i < NROWS; i++) begin
            string tag;
            put_fault(ROWS[i].fen, int'(ROWS[i].first), int'(ROWS[i].last));
            eval(ROWS[i].rev, ROWS[i].vin);
            tag = ROWS[i].fen ? "R5" : (ROWS[i].rev ? "R4" : "R3");
            check({tag, " vec_out"}, vec_out, ROWS[i].eout);
            check("R2 ref_out", ref_out, ROWS[i].eref);
            check("R6 mismatch", {7'd0, mismatch}, {7'd0, ROWS[i].emis});
        end

        // R3 slots at or above the count are inert
        put_fault(1'b0, 0, 0);
        put_count(2);
        eval(1'b0, 8'h01);
        check("R3 count bypass", vec_out, 8'h07);

        // R2 mask bit on the target wire is not a control
        put_gate(0, 8'b0000_0011, 1);
        put_count(1);
        eval(1'b0, 8'h01);
        check("R2 self-mask fires", vec_out, 8'h03);
        eval(1'b0, 8'h02);
        check("R2 self-mask idle", vec_out, 8'h02);

        // R7 identical neighbours cancel
        put_gate(0, 8'b0000_0100, 5);
        put_gate(1, 8'b0000_0100, 5);
        put_count(2);
        put_fault(1'b1, 0, 1);
        eval(1'b0, 8'h04);
        check("R7 pair out", vec_out, 8'h04);
        check("R7 pair flag", {7'd0, mismatch}, 8'h00);
        put_fault(1'b1, 0, 0);
        eval(1'b0, 8'h04);
        check("R7 single out", vec_out, 8'h24);

        // R8 inverted range is rejected
        put_fault(1'b1, 1, 0);
        eval(1'b0, 8'h04);
        check("R8 kept range", vec_out, 8'h24);
        check("R8 kept flag", {7'd0, mismatch}, 8'h01);

        // R10 write in the same cycle as start
        @(negedge clk);
        start = 1'b1; reverse = 1'b0; vec_in = 8'h04;
        flt_we = 1'b1; flt_enable = 1'b0; flt_first = '0; flt_last = '0;
        @(negedge clk);
        start = 1'b0; flt_we = 1'b0;
        check("R10 old fault", {7'd0, mismatch}, 8'h01);
        eval(1'b0, 8'h04);
        check("R10 new fault", {7'd0, mismatch}, 8'h00);
        @(negedge clk);
        start = 1'b1; vec_in = 8'h04;
        gate_we = 1'b1; gate_slot = 5'd1; gate_mask = 8'h00; gate_target = 3'd0;
        @(negedge clk);
        start = 1'b0; gate_we = 1'b0;
        check("R10 old gate", ref_out, 8'h04);
        eval(1'b0, 8'h04);
        check("R10 new gate", ref_out, 8'h25);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule